// File: doc/BRIEF.md
# Ring Occupancy Pressure Monitor

This block sits beside a consumer ring and tells the ring's service loop how hard to work on each pass. It compares the count of valid ring entries against two programmable thresholds and sorts the result into one of three pressure levels: safe, near-full and critical. An external event, such as an interrupt that fires when the ring fills up, raises a sticky pressure flag. While that flag is up, the block reports near-full pressure and doubles the per-pass service budget. The flag drops only when an evaluation finds the ring back in the safe zone. This gives hysteresis: the event raises pressure mode and only a real drain ends it.

Evaluation happens only on an `eval` strobe. On the clock edge where `eval` is high, the block samples the occupancy, the thresholds, the base budget and the current flag. The level, near-full indication and effective budget are held in registers and change only at evaluations. All pins are plain control and status signals. There is no data path that needs flow control, so the block applies no back-pressure.

Top module: `ring_pressure_mon`

## Requirements
- R1: After reset, `level` is 2'b00, `flag` is 0, `near_full` is 0 and `budget` is 16'h0000.
- R2: At an evaluation where `occupancy` is strictly greater than `crit_th`, `level` becomes 2'b10 (critical). This test has priority over the safe test.
- R3: At an evaluation that is not critical, `level` becomes 2'b00 (safe) when `occupancy` is strictly less than `safe_th`, and 2'b01 (near-full) otherwise. Code 2'b11 never appears.
- R4: A high `nf_set` sets `flag` on that clock edge. `flag` then stays 1 until a clearing evaluation.
- R5: At an evaluation where `flag` is 0, `near_full` becomes 0 and `budget` becomes `base_budget` unchanged.
- R6: At an evaluation where `flag` is 1 and the level is near-full or critical, `near_full` becomes 1 and `budget` becomes twice `base_budget`, saturating at 16'hFFFF.
- R7: At an evaluation where `flag` is 1 and the level is safe, `flag` is cleared, `near_full` becomes 0 and `budget` becomes `base_budget`.
- R8: When `nf_set` is high in the same cycle as a clearing evaluation, `flag` stays 1.
- R9: In cycles without `eval`, `level`, `near_full` and `budget` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eval | input | 1 | Evaluation strobe |
| occupancy | input | 16 | Valid entries in the ring |
| safe_th | input | 16 | Occupancy below this value is safe |
| crit_th | input | 16 | Occupancy above this value is critical |
| nf_set | input | 1 | Pulse that raises the sticky pressure flag |
| base_budget | input | 16 | Nominal per-pass budget |
| level | output | 2 | Registered pressure level |
| flag | output | 1 | Sticky pressure flag |
| near_full | output | 1 | Registered near-full indication |
| budget | output | 16 | Registered effective budget |

## Verification
Each result is due one clock edge after its cause. An `eval` sampled at edge k shows its `level`, `near_full` and `budget` after edge k. An `nf_set` at edge k, or a clearing evaluation at edge k, shows in `flag` after that same edge. The bench drives inputs on the falling edge. A reference model advances on the same rising edge as the design, and the bench compares all four outputs at the next falling edge, so every check sees exactly one edge of settled change. In cycles without `eval`, the bench keeps the previous expected outputs, which checks that they hold.

// File: rtl/ring_pressure_pkg.sv
package ring_pressure_pkg;
  localparam int CNT_W = 16;

  typedef enum logic [1:0] {
    LVL_SAFE = 2'b00,
    LVL_NEAR = 2'b01,
    LVL_CRIT = 2'b10
  } press_lvl_e;
endpackage

// File: rtl/rp_classifier.sv
module rp_classifier
  import ring_pressure_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic [W-1:0] occupancy,
  input  logic [W-1:0] safe_th,
  input  logic [W-1:0] crit_th,
  output press_lvl_e   lvl
);
  logic above_crit;
  logic below_safe;

  assign above_crit = occupancy > crit_th;
  assign below_safe = occupancy < safe_th;

  always_comb begin
    if (above_crit)      lvl = LVL_CRIT;
    else if (below_safe) lvl = LVL_SAFE;
    else                 lvl = LVL_NEAR;
  end
endmodule

// File: rtl/rp_flag.sv
module rp_flag
  import ring_pressure_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       eval,
  input  logic       nf_set,
  input  press_lvl_e lvl,
  output logic       flag_q
);
  logic clear_now;

  assign clear_now = eval && flag_q && (lvl == LVL_SAFE);

  // A set pulse outranks a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (nf_set)    flag_q <= 1'b1;
    else if (clear_now) flag_q <= 1'b0;
  end

  p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nf_set |=> flag_q);
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !eval) |=> flag_q);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && flag_q && lvl == LVL_SAFE && !nf_set) |=> !flag_q);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && flag_q && lvl == LVL_SAFE && nf_set) |=> flag_q);
endmodule

// File: rtl/rp_budget.sv
module rp_budget
  import ring_pressure_pkg::*;
#(
  parameter int W = CNT_W,
  parameter int SCALE_SHIFT = 1
) (
  input  logic         flag,
  input  press_lvl_e   lvl,
  input  logic [W-1:0] base,
  output logic         boost,
  output logic [W-1:0] eff
);
  localparam logic [W-1:0] SAT = {W{1'b1}};

  logic [W+SCALE_SHIFT-1:0] wide;
  logic                     ovf;

  assign wide  = {{SCALE_SHIFT{1'b0}}, base} << SCALE_SHIFT;
  assign ovf   = |wide[W+SCALE_SHIFT-1:W];
  assign boost = flag && (lvl != LVL_SAFE);

  always_comb begin
    if (!boost)   eff = base;
    else if (ovf) eff = SAT;
    else          eff = wide[W-1:0];
  end
endmodule

// File: rtl/ring_pressure_mon.sv
module ring_pressure_mon
  import ring_pressure_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         eval,
  input  logic [W-1:0] occupancy,
  input  logic [W-1:0] safe_th,
  input  logic [W-1:0] crit_th,
  input  logic         nf_set,
  input  logic [W-1:0] base_budget,
  output logic [1:0]   level,
  output logic         flag,
  output logic         near_full,
  output logic [W-1:0] budget
);
  press_lvl_e   lvl_c;
  press_lvl_e   lvl_q;
  logic         boost_c;
  logic [W-1:0] eff_c;
  logic         nf_q;
  logic [W-1:0] bud_q;

  rp_classifier #(.W(W)) u_cls (
    .occupancy(occupancy), .safe_th(safe_th), .crit_th(crit_th), .lvl(lvl_c)
  );

  rp_flag u_flag (
    .clk(clk), .rst_n(rst_n), .eval(eval), .nf_set(nf_set),
    .lvl(lvl_c), .flag_q(flag)
  );

  rp_budget #(.W(W), .SCALE_SHIFT(1)) u_bud (
    .flag(flag), .lvl(lvl_c), .base(base_budget),
    .boost(boost_c), .eff(eff_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= LVL_SAFE;
      nf_q  <= 1'b0;
      bud_q <= '0;
    end else if (eval) begin
      lvl_q <= lvl_c;
      nf_q  <= boost_c;
      bud_q <= eff_c;
    end
  end

  assign level     = lvl_q;
  assign near_full = nf_q;
  assign budget    = bud_q;

  p_crit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && occupancy > crit_th) |=> level == 2'b10);
  p_enc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    level != 2'b11);
  p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !flag) |=> (!near_full && budget == $past(base_budget)));
  p_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && flag && occupancy >= safe_th && base_budget[W-1]) |=>
      (near_full && budget == {W{1'b1}}));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !eval |=> ($stable(level) && $stable(near_full) && $stable(budget)));
endmodule

// File: tb/sim_ring_pressure_mon.sv
`timescale 1ns/1ps
module sim_ring_pressure_mon;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eval = 1'b0;
  logic [15:0] occupancy = '0, safe_th = '0, crit_th = '0, base_budget = '0;
  logic        nf_set = 1'b0;
  logic [1:0]  level;
  logic        flag, near_full;
  logic [15:0] budget;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic [1:0]  m_lvl = 2'b00;
  logic        m_flag = 1'b0, m_nf = 1'b0;
  logic [15:0] m_bud = 16'h0;

  always #2.5 clk = ~clk;

  ring_pressure_mon u0 (
    .clk(clk), .rst_n(rst_n), .eval(eval), .occupancy(occupancy),
    .safe_th(safe_th), .crit_th(crit_th), .nf_set(nf_set),
    .base_budget(base_budget), .level(level), .flag(flag),
    .near_full(near_full), .budget(budget)
  );

  function automatic logic [1:0] ref_lvl(logic [15:0] o, logic [15:0] s, logic [15:0] c);
    if (o > c) return 2'b10;
    if (o < s) return 2'b00;
    return 2'b01;
  endfunction

  function automatic logic [15:0] ref_dbl(logic [15:0] b);
    logic [16:0] w;
    w = {1'b0, b} * 17'd2;
    return (w > 17'h0FFFF) ? 16'hFFFF : w[15:0];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, step the model at the rising edge,
  // compare at the following falling edge.
  task automatic cyc(logic e, logic s, logic [15:0] o, logic [15:0] sth,
                     logic [15:0] cth, logic [15:0] b);
    logic [1:0] l;
    logic       old_flag;
    string      lr, fr, br;
    eval = e; nf_set = s; occupancy = o; safe_th = sth; crit_th = cth; base_budget = b;
    l = ref_lvl(o, sth, cth);
    old_flag = m_flag;
    lr = e ? ((l == 2'b10) ? "R2" : "R3") : "R9";
    fr = s ? ((e && old_flag && l == 2'b00) ? "R8" : "R4") :
             ((e && old_flag && l == 2'b00) ? "R7" : "R4");
    br = !e ? "R9" : (!old_flag ? "R5" : ((l == 2'b00) ? "R7" : "R6"));
    if (e) begin
      m_lvl = l;
      m_nf  = old_flag && (l != 2'b00);
      m_bud = m_nf ? ref_dbl(b) : b;
    end
    if (s) m_flag = 1'b1;
    else if (e && old_flag && l == 2'b00) m_flag = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(lr, level, m_lvl);
    chk(fr, flag, m_flag);
    chk(br, near_full, m_nf);
    chk(br, budget, m_bud);
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin : stim
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1", level, 2'b00);
    chk("R1", flag, 1'b0);
    chk("R1", near_full, 1'b0);
    chk("R1", budget, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    cyc(1, 0, 16'd50, 16'd10, 16'd40, 16'd8);    // R2 crit, flag clear -> R5
    cyc(1, 0, 16'd40, 16'd10, 16'd40, 16'd8);    // equal to crit -> near
    cyc(1, 0, 16'd10, 16'd10, 16'd40, 16'd8);    // equal to safe -> near
    cyc(1, 0, 16'd9,  16'd10, 16'd40, 16'd8);    // R3 safe
    cyc(1, 0, 16'd5,  16'd10, 16'd3,  16'd8);    // R2 priority over safe
    cyc(0, 1, 16'd0,  16'd0,  16'd0,  16'd0);    // R4 set
    cyc(0, 0, 16'd0,  16'd0,  16'd0,  16'd0);    // R4 sticky, R9 hold
    cyc(1, 0, 16'd20, 16'd10, 16'd40, 16'd300);  // R6 near doubles
    cyc(1, 0, 16'd90, 16'd10, 16'd40, 16'h8001); // R6 saturates
    cyc(1, 0, 16'd90, 16'd10, 16'd40, 16'h7FFF); // R6 just below saturation
    cyc(1, 1, 16'd2,  16'd10, 16'd40, 16'd77);   // R8 set wins
    cyc(1, 0, 16'd2,  16'd10, 16'd40, 16'd77);   // R7 clear
    cyc(1, 0, 16'd30, 16'd10, 16'd40, 16'd77);   // R5 flag clear pass
    cyc(1, 1, 16'd30, 16'd10, 16'd40, 16'd5);    // set same cycle: old flag used
    cyc(1, 0, 16'd30, 16'd10, 16'd40, 16'd5);    // R6
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] sth, cth, o;
      sth = 16'($urandom_range(0, 200));
      cth = sth + 16'($urandom_range(0, 200));
      o   = 16'($urandom_range(0, 500));
      cyc(($urandom_range(0, 2) != 0), ($urandom_range(0, 5) == 0), o, sth, cth,
          ($urandom_range(0, 7) == 0) ? 16'($urandom) | 16'h8000 : 16'($urandom_range(0, 4000)));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule